// File: doc/BRIEF.md
# External Data Access Decoder

This block sits between a CPU core and the data space reached by move-external style instructions. It holds a 24-bit data pointer made of three bytes: page, high and low. The pointer can be loaded in one cycle or stepped by one, and a step carries through all three bytes. When the core asks for an access, the block takes the pointer value and decides where the access goes. It can go to a 2 KB on-chip RAM window at the bottom of the space, or out to the external bus as a multiplexed bus cycle.

Each access lasts four base cycles plus a programmed number of wait cycles. An external access drives the address-latch pulse, the address phases on the multiplexed low port and the high-byte port, and the read or write strobe. An on-chip access only drives the RAM select, address and write pulse, and it leaves every external pin idle. This frees those pins for general-purpose use. Read data from either path is captured into a holding register on the last cycle of the access.

Top module: `xdata_access_ctrl`

## Requirements
- R1: `ptr_ld_i` loads `ptr_ld_val_i` into the pointer. Otherwise `ptr_inc_i` adds one to the pointer, with the carry running from the low byte (bits 7:0) through the high byte (bits 15:8) into the page byte (bits 23:16). FFFFFFh wraps to 000000h. The pointer is 000000h after reset.
- R2: When `ram_en_i` is 1 at the accepting edge and the pointer is in 000000h..0007FFh, the access is on-chip. `ram_sel_o` is high for every busy cycle and `ram_addr_o` equals pointer bits 10:0.
- R3: An address of 000800h or above is always external, even when `ram_en_i` is 1.
- R4: When `ram_en_i` is 0, every address is external, including 000000h..0007FFh.
- R5: During an on-chip access, `ext_rd_o`, `ext_wr_o`, `ale_o`, `bus_lo_oe_o` and `bus_hi_oe_o` all stay 0.
- R6: A request seen while idle starts an access on the next cycle. `busy_o` is then high for exactly 4+N cycles, where N is `wait_i` sampled at acceptance.
- R7: A request that arrives while busy is ignored and does not restart or lengthen the access.
- R8: In an external access, `ale_o` is high only in cycle 0, and not at all when `ale_off_i` is 1. In cycle 0, `bus_lo_o` carries the low byte (`addr_phase_o`=1). In cycle 1 it carries the page byte (`addr_phase_o`=2). `bus_hi_o` carries the high byte for the whole access. Data cycles show `addr_phase_o`=3.
- R9: An external read asserts `ext_rd_o` in cycles 2..L-1, where L=4+N. `ext_rdata_i` is captured at the end of cycle L-1 and appears on `rdata_o` once busy falls.
- R10: An external write asserts `ext_wr_o` in cycles 2..L-2, so it drops one cycle before the end. `bus_lo_o` drives the write byte with `bus_lo_oe_o` high in cycles 2..L-1.
- R11: An on-chip write gives a single `ram_we_o` pulse in the last cycle, with `ram_wdata_o` holding the write byte. An on-chip read captures `ram_rdata_i` into `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| ram_en_i | input | 1 | Enables the on-chip 2 KB window |
| ale_off_i | input | 1 | Suppresses the address-latch pulse |
| wait_i | input | WAIT_W | Number of wait cycles |
| ptr_ld_i | input | 1 | Pointer load strobe |
| ptr_ld_val_i | input | 24 | Pointer load value |
| ptr_inc_i | input | 1 | Pointer increment strobe |
| wdata_i | input | 8 | Write byte |
| ext_rdata_i | input | 8 | Read byte from external bus |
| ram_rdata_i | input | 8 | Read byte from on-chip RAM |
| ptr_o | output | 24 | Current pointer |
| busy_o | output | 1 | Access in progress |
| rdata_o | output | 8 | Captured read byte |
| ram_sel_o | output | 1 | On-chip RAM select |
| ram_we_o | output | 1 | On-chip RAM write pulse |
| ram_addr_o | output | 11 | On-chip RAM address |
| ram_wdata_o | output | 8 | On-chip RAM write byte |
| ext_rd_o | output | 1 | External read strobe, active high |
| ext_wr_o | output | 1 | External write strobe, active high |
| ale_o | output | 1 | Address latch enable |
| addr_phase_o | output | 2 | 0 idle, 1 low byte, 2 page byte, 3 data |
| bus_lo_o | output | 8 | Multiplexed low port value |
| bus_lo_oe_o | output | 1 | Low port drive enable |
| bus_hi_o | output | 8 | High address byte port |
| bus_hi_oe_o | output | 1 | High port drive enable |

## Verification
Some properties are checked on every cycle. These are: no external pin is active while the RAM is selected, nothing goes on-chip above the 2 KB window, busy holds until the last cycle, a request during busy leaves the latched access untouched, the latch pulse lasts one cycle, the write strobe is already low in the final cycle, and the pointer steps by exactly one. Other behaviour can only be shown by the bench's scenarios, which use a behavioural external memory and a RAM model. These cover the exact access length for several wait counts, routing on each side of 7FFh/800h with the window on and off, the full 24-bit address rebuilt from the bus phases, read data round trips on both paths, and pointer carry across FFFFh and FFFFFFh.

// File: rtl/xdata_pkg.sv
package xdata_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ADDR_LO = 2'd1,
    PH_ADDR_PG = 2'd2,
    PH_DATA    = 2'd3
  } xd_phase_e;
endpackage

// File: rtl/xd_pointer.sv
module xd_pointer #(
  parameter int BYTES = 3,
  localparam int AW = BYTES * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  logic [BYTES:0] carry;
  logic [AW-1:0]  nxt;

  assign carry[0] = inc_i;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign nxt[b*8 +: 8]  = ptr_o[b*8 +: 8] + {7'd0, carry[b]};
    assign carry[b+1]     = carry[b] & (&ptr_o[b*8 +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (ld_i)   ptr_o <= ld_val_i;
    else if (inc_i)  ptr_o <= nxt;
  end

  // R1
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i) |=> (ptr_o == AW'($past(ptr_o) + 1'b1)));
endmodule

// File: rtl/xd_decode.sv
module xd_decode #(
  parameter int AW    = 24,
  parameter int WIN_W = 11
) (
  input  logic [AW-1:0] addr_i,
  input  logic          win_en_i,
  output logic          ext_o
);
  assign ext_o = !(win_en_i && (addr_i[AW-1:WIN_W] == '0));
endmodule

// File: rtl/xd_seq.sv
module xd_seq #(
  parameter int WAIT_W = 4,
  localparam int CNT_W = WAIT_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ext_i,
  input  logic              we_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              ale_off_i,
  output logic              start_o,
  output logic              active_o,
  output logic              ext_o,
  output logic              we_o,
  output logic              last_o,
  output xdata_pkg::xd_phase_e phase_o,
  output logic              ale_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              lo_oe_o,
  output logic              hi_oe_o,
  output logic              ram_sel_o,
  output logic              ram_we_o,
  output logic              capture_o
);
  import xdata_pkg::*;

  logic             active_q, ext_q, we_q;
  logic [CNT_W-1:0] cnt_q, last_q;

  assign start_o = req_i && !active_q;
  assign last_o  = active_q && (cnt_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ext_q    <= 1'b0;
      we_q     <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
    end else if (start_o) begin
      active_q <= 1'b1;
      ext_q    <= ext_i;
      we_q     <= we_i;
      cnt_q    <= '0;
      last_q   <= CNT_W'(3) + CNT_W'(wait_i);
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      else        cnt_q    <= cnt_q + 1'b1;
    end
  end

  logic ext_act, data_cyc;
  assign ext_act  = active_q && ext_q;
  assign data_cyc = cnt_q >= CNT_W'(2);

  always_comb begin
    if (!active_q)              phase_o = PH_IDLE;
    else if (cnt_q == '0)       phase_o = PH_ADDR_LO;
    else if (cnt_q == CNT_W'(1)) phase_o = PH_ADDR_PG;
    else                        phase_o = PH_DATA;
  end

  assign active_o  = active_q;
  assign ext_o     = ext_q;
  assign we_o      = we_q;
  assign ale_o     = ext_act && (cnt_q == '0) && !ale_off_i;
  assign rd_o      = ext_act && !we_q && data_cyc;
  assign wr_o      = ext_act && we_q && data_cyc && !last_o;
  assign lo_oe_o   = ext_act && (!data_cyc || we_q);
  assign hi_oe_o   = ext_act;
  assign ram_sel_o = active_q && !ext_q;
  assign ram_we_o  = ram_sel_o && we_q && last_o;
  assign capture_o = last_o && !we_q;

  // R6
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !last_o) |=> active_q);

  // R7
  req_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && req_i) |=> ($stable(ext_q) && $stable(we_q) && $stable(last_q) && cnt_q != '0));

  // R8
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  // R10
  wr_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> !$past(wr_o));
endmodule

// File: rtl/xdata_access_ctrl.sv
module xdata_access_ctrl #(
  parameter int PTR_BYTES = 3,
  parameter int WIN_W     = 11,
  parameter int WAIT_W    = 4,
  localparam int AW       = PTR_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ram_en_i,
  input  logic              ale_off_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              ptr_ld_i,
  input  logic [AW-1:0]     ptr_ld_val_i,
  input  logic              ptr_inc_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        ext_rdata_i,
  input  logic [7:0]        ram_rdata_i,
  output logic [AW-1:0]     ptr_o,
  output logic              busy_o,
  output logic [7:0]        rdata_o,
  output logic              ram_sel_o,
  output logic              ram_we_o,
  output logic [WIN_W-1:0]  ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o,
  output logic              ale_o,
  output logic [1:0]        addr_phase_o,
  output logic [7:0]        bus_lo_o,
  output logic              bus_lo_oe_o,
  output logic [7:0]        bus_hi_o,
  output logic              bus_hi_oe_o
);
  import xdata_pkg::*;

  logic          is_ext, start, active, ext_q, we_q, last, capture;
  logic          lo_oe, hi_oe;
  xd_phase_e     phase;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdata_q;

  xd_pointer #(.BYTES(PTR_BYTES)) u_ptr (
    .clk_i, .rst_ni, .ld_i(ptr_ld_i), .ld_val_i(ptr_ld_val_i),
    .inc_i(ptr_inc_i), .ptr_o
  );

  xd_decode #(.AW(AW), .WIN_W(WIN_W)) u_dec (
    .addr_i(ptr_o), .win_en_i(ram_en_i), .ext_o(is_ext)
  );

  xd_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i, .rst_ni, .req_i, .ext_i(is_ext), .we_i, .wait_i, .ale_off_i,
    .start_o(start), .active_o(active), .ext_o(ext_q), .we_o(we_q),
    .last_o(last), .phase_o(phase), .ale_o, .rd_o(ext_rd_o), .wr_o(ext_wr_o),
    .lo_oe_o(lo_oe), .hi_oe_o(hi_oe), .ram_sel_o, .ram_we_o, .capture_o(capture)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_o <= '0;
    end else begin
      if (start) begin
        addr_q  <= ptr_o;
        wdata_q <= wdata_i;
      end
      if (capture) rdata_o <= ext_q ? ext_rdata_i : ram_rdata_i;
    end
  end

  always_comb begin
    bus_lo_o = 8'h00;
    if (lo_oe) begin
      unique case (phase)
        PH_ADDR_LO: bus_lo_o = addr_q[7:0];
        PH_ADDR_PG: bus_lo_o = addr_q[AW-1 -: 8];
        PH_DATA:    bus_lo_o = wdata_q;
        default:    bus_lo_o = 8'h00;
      endcase
    end
  end

  assign bus_hi_o     = hi_oe ? addr_q[15:8] : 8'h00;
  assign bus_lo_oe_o  = lo_oe;
  assign bus_hi_oe_o  = hi_oe;
  assign busy_o       = active;
  assign addr_phase_o = phase;
  assign ram_addr_o   = addr_q[WIN_W-1:0];
  assign ram_wdata_o  = wdata_q;

  // R5
  int_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_sel_o |-> !(ext_rd_o || ext_wr_o || ale_o || bus_lo_oe_o || bus_hi_oe_o));

  // R3
  win_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && addr_q[AW-1:WIN_W] != '0) |-> !ram_sel_o);

  // R9
  rd_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && ext_q && !we_q) |-> ext_rd_o);
endmodule

// File: tb/sim_xdata_access_ctrl.sv
module sim_xdata_access_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, ram_en = 1'b0, ale_off = 1'b0;
  logic [3:0]  wt = 4'd0;
  logic        ptr_ld = 1'b0, ptr_inc = 1'b0;
  logic [23:0] ptr_val = '0;
  logic [7:0]  wdata = '0, ext_rdata = '0, ram_rdata;
  logic [23:0] ptr;
  logic        busy, ram_sel, ram_we, ext_rd, ext_wr, ale, lo_oe, hi_oe;
  logic [7:0]  rdata, ram_wdata, bus_lo, bus_hi;
  logic [10:0] ram_addr;
  logic [1:0]  phase;

  always #4 clk = ~clk;

  xdata_access_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .ram_en_i(ram_en),
    .ale_off_i(ale_off), .wait_i(wt), .ptr_ld_i(ptr_ld), .ptr_ld_val_i(ptr_val),
    .ptr_inc_i(ptr_inc), .wdata_i(wdata), .ext_rdata_i(ext_rdata),
    .ram_rdata_i(ram_rdata), .ptr_o(ptr), .busy_o(busy), .rdata_o(rdata),
    .ram_sel_o(ram_sel), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ext_rd_o(ext_rd), .ext_wr_o(ext_wr), .ale_o(ale),
    .addr_phase_o(phase), .bus_lo_o(bus_lo), .bus_lo_oe_o(lo_oe),
    .bus_hi_o(bus_hi), .bus_hi_oe_o(hi_oe)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req_tag, what, act, exp);
    end
  endtask

  // behavioural memories
  logic [7:0] iram [2048];
  logic [7:0] xmem [logic [23:0]];
  logic [7:0] ref_i [2048];
  logic [7:0] ref_x [logic [23:0]];
  assign ram_rdata = iram[ram_addr];

  typedef struct {
    bit          ext;
    bit          rd;
    int          len;
    logic [7:0]  data;
    bit          ale;
    logic [23:0] addr;
    string       tag;
  } exp_t;
  exp_t q[$];

  // monitor
  int c_cyc = 0, c_rd = 0, c_wr = 0, c_ale = 0, c_ext = 0, c_sel = 0, c_rwe = 0;
  logic [7:0]  m_lo = '0, m_pg = '0;
  logic [23:0] m_addr = '0;
  bit          m_phase_ok = 1'b1;

  always @(negedge clk) begin
    if (busy) begin
      if (c_cyc == 0) begin
        m_lo = bus_lo;
        if (hi_oe && phase != 2'd1) m_phase_ok = 1'b0;
      end
      if (c_cyc == 1) begin
        m_pg = bus_lo;
        m_addr = {bus_lo, bus_hi, m_lo};
        ext_rdata = xmem.exists(m_addr) ? xmem[m_addr] : 8'h00;
        if (hi_oe && phase != 2'd2) m_phase_ok = 1'b0;
      end
      if (c_cyc >= 2 && hi_oe && phase != 2'd3) m_phase_ok = 1'b0;
      if (ext_rd) c_rd++;
      if (ext_wr) begin
        c_wr++;
        xmem[{m_pg, bus_hi, m_lo}] = bus_lo;
      end
      if (ale) c_ale++;
      if (ext_rd || ext_wr || ale || lo_oe || hi_oe) c_ext++;
      if (ram_sel) c_sel++;
      if (ram_we) begin
        c_rwe++;
        iram[ram_addr] = ram_wdata;
      end
      c_cyc++;
    end else if (c_cyc != 0) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7", "unexpected extra access", 32'(c_cyc), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(c_cyc == e.len, "R6", "busy length", 32'(c_cyc), 32'(e.len));
        chk((c_ext > 0) == e.ext, e.tag, "external routing", 32'(c_ext > 0), 32'(e.ext));
        if (e.ext) begin
          chk(c_ale == (e.ale ? 1 : 0), "R8", "ale cycles", 32'(c_ale), e.ale ? 1 : 0);
          chk(m_addr == e.addr, "R8", "bus address", 32'(m_addr), 32'(e.addr));
          chk(m_phase_ok, "R8", "phase code", 0, 1);
          if (e.rd) begin
            chk(c_rd == e.len - 2, "R9", "read strobe cycles", 32'(c_rd), 32'(e.len - 2));
            chk(rdata == e.data, "R9", "ext read data", 32'(rdata), 32'(e.data));
          end else begin
            chk(c_wr == e.len - 3, "R10", "write strobe cycles", 32'(c_wr), 32'(e.len - 3));
          end
        end else begin
          chk(c_ext == 0, "R5", "ext pins during on-chip", 32'(c_ext), 0);
          chk(c_sel == e.len, "R2", "ram select cycles", 32'(c_sel), 32'(e.len));
          if (e.rd) chk(rdata == e.data, "R11", "ram read data", 32'(rdata), 32'(e.data));
          else      chk(c_rwe == 1, "R11", "ram write pulses", 32'(c_rwe), 1);
        end
      end
      c_cyc = 0; c_rd = 0; c_wr = 0; c_ale = 0; c_ext = 0; c_sel = 0; c_rwe = 0;
      m_phase_ok = 1'b1;
    end
  end

  task automatic load_ptr(input logic [23:0] v);
    ptr_ld = 1'b1; ptr_val = v;
    @(negedge clk);
    ptr_ld = 1'b0;
  endtask

  // driver: pushes expectation, then runs the access
  task automatic access(input bit w, input logic [23:0] a, input logic [7:0] d,
                        input int n, input string tag);
    exp_t e;
    load_ptr(a);
    e.ext  = !(ram_en && a <= 24'h0007FF);
    e.rd   = !w;
    e.len  = 4 + n;
    e.ale  = !ale_off;
    e.addr = a;
    e.tag  = tag;
    e.data = 8'h00;
    if (w) begin
      if (e.ext) ref_x[a] = d; else ref_i[a[10:0]] = d;
    end else begin
      if (e.ext) e.data = ref_x.exists(a) ? ref_x[a] : 8'h00;
      else       e.data = ref_i[a[10:0]];
    end
    q.push_back(e);
    req = 1'b1; we = w; wdata = d; wt = 4'(n);
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  bit fin = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin
      iram[i] = 8'h00;
      ref_i[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R6)
    chk(ptr == 24'h0, "R1", "pointer after reset", 32'(ptr), 0);
    chk(!busy && !ext_rd && !ext_wr && !ale && !ram_sel, "R6", "idle after reset",
        32'({busy, ext_rd, ext_wr, ale, ram_sel}), 0);

    // pointer carry (R1)
    load_ptr(24'h00FFFF);
    ptr_inc = 1'b1; @(negedge clk); ptr_inc = 1'b0;
    chk(ptr == 24'h010000, "R1", "carry into page", 32'(ptr), 32'h010000);
    load_ptr(24'h0000FF);
    ptr_inc = 1'b1; @(negedge clk); ptr_inc = 1'b0;
    chk(ptr == 24'h000100, "R1", "carry into high", 32'(ptr), 32'h000100);
    load_ptr(24'hFFFFFF);
    ptr_inc = 1'b1; @(negedge clk); ptr_inc = 1'b0;
    chk(ptr == 24'h000000, "R1", "full wrap", 32'(ptr), 0);

    // on-chip window boundary (R2, R3, R11)
    ram_en = 1'b1;
    access(1'b1, 24'h0007FF, 8'hA5, 0, "R2");
    access(1'b0, 24'h0007FF, 8'h00, 2, "R2");
    access(1'b1, 24'h000000, 8'h3C, 1, "R2");
    access(1'b1, 24'h000800, 8'h5A, 0, "R3");
    access(1'b0, 24'h000800, 8'h00, 3, "R3");
    access(1'b0, 24'h000000, 8'h00, 0, "R2");

    // window disabled (R4)
    ram_en = 1'b0;
    access(1'b1, 24'h000010, 8'hC3, 5, "R4");
    access(1'b0, 24'h000010, 8'h00, 2, "R4");
    access(1'b0, 24'h0007FF, 8'h00, 0, "R4");

    // page byte through the bus (R8)
    access(1'b1, 24'h012345, 8'h77, 1, "R8");
    access(1'b0, 24'h002345, 8'h00, 0, "R8");
    access(1'b0, 24'h012345, 8'h00, 15, "R8");

    // address latch pulse suppressed (R8)
    ale_off = 1'b1;
    access(1'b1, 24'hFF0800, 8'h99, 4, "R8");
    access(1'b0, 24'hFF0800, 8'h00, 1, "R8");
    ale_off = 1'b0;

    // request during busy (R7)
    begin
      exp_t e;
      load_ptr(24'h001234);
      ref_x[24'h001234] = 8'h42;
      e.ext = 1'b1; e.rd = 1'b0; e.len = 6; e.ale = 1'b1;
      e.addr = 24'h001234; e.tag = "R7"; e.data = 8'h00;
      q.push_back(e);
      req = 1'b1; we = 1'b1; wdata = 8'h42; wt = 4'd2;
      @(negedge clk);
      req = 1'b0; wt = 4'd9;
      @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(!busy, "R7", "no restart after busy", 32'(busy), 0);
      chk(q.size() == 0, "R7", "single completion", 32'(q.size()), 0);
    end
    access(1'b0, 24'h001234, 8'h00, 0, "R7");

    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R6", "all accesses completed", 32'(q.size()), 0);
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule